// File: doc/BRIEF.md
# Cartridge PRG Bank Mapper with Cycle-Count Interrupt

This block sits between an 8-bit CPU bus and a cartridge program ROM. It produces the upper three ROM address lines (A15..A13) for each CPU access, so that the CPU sees five 8 KiB windows from $6000 to $FFFF. Four of them always show the same ROM bank. The window at $C000-$DFFF shows whichever bank software last loaded. It also drives the ROM enable, and it keeps the ROM off the data bus whenever the CPU writes.

CPU writes to $8000-$FFFF never reach the ROM. They land in one of four register slots, selected by CPU A14..A13. One slot loads the bank, one arms an interrupt timer, and one disarms the timer and clears a pending interrupt. The fourth slot does nothing. Once armed, the timer counts M2 cycles from zero. After 4096 cycles it pulls the active-low IRQ line low, and the line stays low until software acknowledges it.

All state changes on the rising edge of M2. Reset is asynchronous and active low.

Top module: `cart_bank_irq`

## Requirements
- R1: A register write is a CPU write (`cpu_rw`=0) with `romsel_n`=0. It is decoded by `cpu_addr[14:13]`: 00 is the acknowledge slot ($8000), 01 the arm slot ($A000), 10 the unused slot ($C000) and 11 the bank slot ($E000). At most one slot fires per cycle, and reads fire none.
- R2: A write to the acknowledge slot disarms the timer and releases the interrupt, so `irq_n` is 1 after that edge. The interrupt stays off while the timer is disarmed.
- R3: A write to the arm slot starts the timer at zero. `irq_n` goes low after the 4096th rising M2 edge that follows the arming edge, and not before. A second arm write while the timer is already running does not restart the count.
- R4: A write to the bank slot loads `cpu_data[2:0]` into the bank register. A read with `romsel_n`=0 and `cpu_addr[14:13]`=10 ($C000-$DFFF) drives `prg_addr_hi` with that bank.
- R5: The other windows are fixed. `prg_addr_hi` (bit 2 = PRG A15, bit 0 = PRG A13) is 6 for `romsel_n`=1 with `cpu_addr[14:13]`=11 ($6000). With `romsel_n`=0 it is 4 for `cpu_addr[14:13]`=00, 5 for 01 and 7 for 11.
- R6: `prg_oe` is 1 only on reads in $6000-$FFFF, that is, when `romsel_n`=0, or when `romsel_n`=1 with `cpu_addr[14:13]`=11. It is 0 on every write and on reads elsewhere.
- R7: `irq_n` is active low. Once low, it stays low until an acknowledge write, even across further arm writes or unused-slot writes. While the timer is disarmed its count is held at zero.
- R8: A write to the unused slot ($C000) changes neither the bank nor the timer state.
- R9: After reset the timer is disarmed, `irq_n` is 1 and the bank register is 0.
- R10: Writes with `romsel_n`=1 (below $8000) touch no register, whatever `cpu_addr[14:13]` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m2 | input | 1 | CPU phase clock; state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 15 | CPU address lines A14..A0 |
| cpu_rw | input | 1 | CPU read/write, 1 = read |
| cpu_data | input | 8 | CPU data bus as seen during writes |
| romsel_n | input | 1 | Active-low ROM select (CPU A15 qualified by M2) |
| prg_addr_hi | output | 3 | PRG ROM address lines A15..A13 |
| prg_oe | output | 1 | PRG ROM output enable, active high |
| irq_n | output | 1 | Active-low interrupt request to the CPU |

## Verification
The bench checks the interrupt edge exactly. It expects `irq_n` still high after the 4095th counted edge and low after the 4096th, so an off-by-one counter, or a tap on the wrong counter stage, fails at once. A re-arm write in the middle of a count must not move that edge, which exposes a design that clears the counter on every arm write. Writes to the unused slot, and writes with ROM select inactive but matching slot bits, are each followed by a read-back of the bank window and an interrupt check, so loose decoding shows up as a changed bank or a spurious interrupt. A write cycle that enabled the ROM would show `prg_oe` high during the store.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int ADDR_W    = 15;
  localparam int DATA_W    = 8;
  localparam int HI_W      = 3;
  localparam int BANK_W    = HI_W;
  localparam int NUM_SLOTS = 4;

  typedef enum logic [1:0] {
    SLOT_ACK  = 2'b00,
    SLOT_ARM  = 2'b01,
    SLOT_NONE = 2'b10,
    SLOT_BANK = 2'b11
  } reg_slot_e;

  // Bank shown by the fixed windows: A15 high, A14 passes, A13 passes only in ROM space
  function automatic logic [HI_W-1:0] fixed_hi(input logic romsel_n, input logic a14,
                                               input logic a13);
    return {1'b1, a14, a13 & ~romsel_n};
  endfunction

  function automatic logic in_switch_window(input logic romsel_n, input logic a14,
                                            input logic a13);
    return ~romsel_n & a14 & ~a13;
  endfunction

  function automatic logic in_rom_range(input logic romsel_n, input logic a14,
                                        input logic a13);
    return ~romsel_n | (a14 & a13);
  endfunction
endpackage

// File: rtl/cart_reg_decode.sv
module cart_reg_decode
  import cart_map_pkg::*;
(
  input  logic                 romsel_n,
  input  logic                 cpu_rw,
  input  logic [1:0]           slot_sel,
  output logic [NUM_SLOTS-1:0] wr_slot
);
  logic wr_any;
  assign wr_any = ~cpu_rw & ~romsel_n;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign wr_slot[s] = wr_any && (slot_sel == s[1:0]);
  end
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg
  import cart_map_pkg::*;
(
  input  logic              m2,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] din,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge m2 or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= din;
  end
endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
  import cart_map_pkg::*;
(
  input  logic              romsel_n,
  input  logic              cpu_rw,
  input  logic              a14,
  input  logic              a13,
  input  logic [BANK_W-1:0] bank_q,
  output logic [HI_W-1:0]   prg_addr_hi,
  output logic              prg_oe
);
  always_comb begin
    if (in_switch_window(romsel_n, a14, a13)) prg_addr_hi = bank_q;
    else                                      prg_addr_hi = fixed_hi(romsel_n, a14, a13);
    prg_oe = cpu_rw & in_rom_range(romsel_n, a14, a13);
  end
endmodule

// File: rtl/cart_irq_timer.sv
module cart_irq_timer #(
  parameter int CNT_W = 13
) (
  input  logic             m2,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             ack,
  output logic             irq_en,
  output logic [CNT_W-1:0] irq_cnt,
  output logic             irq_fire
);
  localparam int TOP = CNT_W - 1;

  assign irq_fire = irq_cnt[TOP];

  always_ff @(posedge m2 or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= 1'b0;
      irq_cnt <= '0;
    end else if (ack) begin
      irq_en  <= 1'b0;
      irq_cnt <= '0;
    end else begin
      if (arm) irq_en <= 1'b1;
      if (irq_en && !irq_cnt[TOP]) irq_cnt <= irq_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cart_bank_irq.sv
module cart_bank_irq
  import cart_map_pkg::*;
#(
  parameter int IRQ_STAGE = 13
) (
  input  logic              m2,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              romsel_n,
  output logic [HI_W-1:0]   prg_addr_hi,
  output logic              prg_oe,
  output logic              irq_n
);
  localparam int CNT_W = IRQ_STAGE;

  logic                 a14, a13;
  logic [NUM_SLOTS-1:0] wr_slot;
  logic                 wr_ack, wr_arm, wr_none, wr_bank;
  logic [BANK_W-1:0]    bank_q;
  logic                 irq_en, irq_fire;
  logic [CNT_W-1:0]     irq_cnt;
  logic                 unused_bits;

  assign a14 = cpu_addr[ADDR_W-1];
  assign a13 = cpu_addr[ADDR_W-2];
  assign unused_bits = ^{cpu_addr[ADDR_W-3:0], cpu_data[DATA_W-1:BANK_W]};

  cart_reg_decode u_dec (
    .romsel_n (romsel_n),
    .cpu_rw   (cpu_rw),
    .slot_sel ({a14, a13}),
    .wr_slot  (wr_slot)
  );

  assign wr_ack  = wr_slot[SLOT_ACK];
  assign wr_arm  = wr_slot[SLOT_ARM];
  assign wr_none = wr_slot[SLOT_NONE];
  assign wr_bank = wr_slot[SLOT_BANK];

  cart_bank_reg u_bank (
    .m2     (m2),
    .rst_n  (rst_n),
    .load   (wr_bank),
    .din    (cpu_data[BANK_W-1:0]),
    .bank_q (bank_q)
  );

  cart_bank_map u_map (
    .romsel_n    (romsel_n),
    .cpu_rw      (cpu_rw),
    .a14         (a14),
    .a13         (a13),
    .bank_q      (bank_q),
    .prg_addr_hi (prg_addr_hi),
    .prg_oe      (prg_oe)
  );

  cart_irq_timer #(.CNT_W(CNT_W)) u_irq (
    .m2       (m2),
    .rst_n    (rst_n),
    .arm      (wr_arm),
    .ack      (wr_ack),
    .irq_en   (irq_en),
    .irq_cnt  (irq_cnt),
    .irq_fire (irq_fire)
  );

  assign irq_n = ~irq_fire;
endmodule

// File: rtl/cart_bank_irq_chk.sv
module cart_bank_irq_chk
  import cart_map_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input logic              m2,
  input logic              rst_n,
  input logic              a14,
  input logic              a13,
  input logic              cpu_rw,
  input logic              romsel_n,
  input logic [BANK_W-1:0] bank_din,
  input logic [HI_W-1:0]   prg_addr_hi,
  input logic              prg_oe,
  input logic              irq_n,
  input logic              wr_ack,
  input logic              wr_arm,
  input logic              wr_none,
  input logic              wr_bank,
  input logic [BANK_W-1:0] bank_q,
  input logic              irq_en,
  input logic [CNT_W-1:0]  irq_cnt
);
  p_onehot_slot_r1: assert property (@(posedge m2) disable iff (!rst_n)
    $onehot0({wr_ack, wr_arm, wr_none, wr_bank}));

  p_low_writes_ignored_r10: assert property (@(posedge m2) disable iff (!rst_n)
    romsel_n |-> !(wr_ack || wr_arm || wr_none || wr_bank));

  p_ack_releases_r2: assert property (@(posedge m2) disable iff (!rst_n)
    wr_ack |=> (irq_n && !irq_en));

  p_arm_sets_r3: assert property (@(posedge m2) disable iff (!rst_n)
    (wr_arm && !wr_ack) |=> irq_en);

  p_bank_load_r4: assert property (@(posedge m2) disable iff (!rst_n)
    wr_bank |=> (bank_q == $past(bank_din)));

  p_switch_window_r4: assert property (@(posedge m2) disable iff (!rst_n)
    (!romsel_n && a14 && !a13) |-> (prg_addr_hi == bank_q));

  p_window_6000_r5: assert property (@(posedge m2) disable iff (!rst_n)
    (romsel_n && a14 && a13) |-> (prg_addr_hi == 3'd6));

  p_window_8000_r5: assert property (@(posedge m2) disable iff (!rst_n)
    (!romsel_n && !a14 && !a13) |-> (prg_addr_hi == 3'd4));

  p_window_e000_r5: assert property (@(posedge m2) disable iff (!rst_n)
    (!romsel_n && a14 && a13) |-> (prg_addr_hi == 3'd7));

  p_no_bus_drive_r6: assert property (@(posedge m2) disable iff (!rst_n)
    !cpu_rw |-> !prg_oe);

  p_irq_sticky_r7: assert property (@(posedge m2) disable iff (!rst_n)
    (!irq_n && !wr_ack) |=> !irq_n);

  p_held_zero_r7: assert property (@(posedge m2) disable iff (!rst_n)
    !irq_en |-> (irq_cnt == '0 && irq_n));

  p_none_slot_r8: assert property (@(posedge m2) disable iff (!rst_n)
    wr_none |=> ($stable(bank_q) && $stable(irq_en)));
endmodule

bind cart_bank_irq cart_bank_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .m2          (m2),
  .rst_n       (rst_n),
  .a14         (a14),
  .a13         (a13),
  .cpu_rw      (cpu_rw),
  .romsel_n    (romsel_n),
  .bank_din    (cpu_data[2:0]),
  .prg_addr_hi (prg_addr_hi),
  .prg_oe      (prg_oe),
  .irq_n       (irq_n),
  .wr_ack      (wr_ack),
  .wr_arm      (wr_arm),
  .wr_none     (wr_none),
  .wr_bank     (wr_bank),
  .bank_q      (bank_q),
  .irq_en      (irq_en),
  .irq_cnt     (irq_cnt)
);

// File: tb/cart_bank_irq_test.sv
`timescale 1ns/100ps
module cart_bank_irq_test;
  logic        m2 = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] cpu_addr = 15'h0;
  logic        cpu_rw = 1'b1;
  logic [7:0]  cpu_data = 8'h0;
  logic        romsel_n = 1'b1;
  logic [2:0]  prg_addr_hi;
  logic        prg_oe, irq_n;

  cart_bank_irq uut (
    .m2(m2), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_data(cpu_data), .romsel_n(romsel_n), .prg_addr_hi(prg_addr_hi),
    .prg_oe(prg_oe), .irq_n(irq_n)
  );

  always #2 m2 = ~m2;

  // kind: 0 = prg_addr_hi, 1 = prg_oe, 2 = irq_n
  typedef struct {
    string req;
    int    kind;
    int    exp;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  int    bank_m = 0;

  localparam int IRQ_CYCLES = 4096;

  // Expected A15..A13 from the full 16-bit CPU address
  function automatic int exp_window(input logic [15:0] a, input int bank);
    case (a[15:13])
      3'd3:    return 6;
      3'd4:    return 4;
      3'd5:    return 5;
      3'd6:    return bank;
      3'd7:    return 7;
      default: return 0;
    endcase
  endfunction

  task automatic push(input string req, input int kind, input int exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
    -> mon_ev;
  endtask

  task automatic cyc(input logic [15:0] a, input bit wr, input logic [7:0] d);
    @(negedge m2);
    cpu_addr = a[14:0];
    romsel_n = ~a[15];
    cpu_rw   = ~wr;
    cpu_data = d;
    #1;
  endtask

  task automatic idle();
    cyc(16'h6000, 1'b0, 8'h00);
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) idle();
  endtask

  task automatic read_chk(input logic [15:0] a, input string req);
    cyc(a, 1'b0, 8'h00);
    push(req, 0, exp_window(a, bank_m));
    push(req, 1, 1);
  endtask

  initial begin
    forever begin
      @(mon_ev);
      while (q.size() != 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.kind)
          0:       act = int'(prg_addr_hi);
          1:       act = int'(prg_oe);
          default: act = int'(irq_n);
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge m2);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    cyc(16'hC000, 1'b0, 8'h00);
    push("R9 bank cleared", 0, 0);
    push("R9 irq released", 2, 1);
    @(negedge m2);
    rst_n = 1'b1;
    idles(IRQ_CYCLES + 100);
    push("R9 timer disarmed", 2, 1);

    // R5/R6: fixed windows and enable
    read_chk(16'h6000, "R5 6000");
    read_chk(16'h7FFF, "R5 7FFF");
    read_chk(16'h8000, "R5 8000");
    read_chk(16'h9FFF, "R5 9FFF");
    read_chk(16'hA000, "R5 A000");
    read_chk(16'hBFFF, "R5 BFFF");
    read_chk(16'hE000, "R5 E000");
    read_chk(16'hFFFF, "R5 FFFF");
    cyc(16'h4000, 1'b0, 8'h00);
    push("R6 read 4000 disabled", 1, 0);
    cyc(16'h0123, 1'b0, 8'h00);
    push("R6 read 0123 disabled", 1, 0);

    // R4: bank loading
    cyc(16'hE000, 1'b1, 8'h03);
    push("R6 write no drive", 1, 0);
    bank_m = 3;
    read_chk(16'hDFFF, "R4 bank 3");
    cyc(16'hF00F, 1'b1, 8'hFD);
    bank_m = 5;
    read_chk(16'hC000, "R4 bank low bits 5");

    // R8: unused slot
    cyc(16'hC000, 1'b1, 8'h02);
    push("R8 write C000 no drive", 1, 0);
    read_chk(16'hC123, "R8 bank kept");
    push("R8 timer untouched", 2, 1);

    // R10: writes below $8000 ignored
    cyc(16'h6000, 1'b1, 8'h01);
    cyc(16'h4000, 1'b1, 8'h01);
    read_chk(16'hC000, "R10 bank kept");
    cyc(16'h2000, 1'b1, 8'h00);
    idles(IRQ_CYCLES + 100);
    push("R10 low arm ignored", 2, 1);

    // R3: exact interrupt edge
    cyc(16'hA000, 1'b1, 8'h00);
    for (int k = 1; k <= IRQ_CYCLES + 1; k++) begin
      idle();
      if (k == IRQ_CYCLES)     push("R3 not before 4096", 2, 1);
      if (k == IRQ_CYCLES + 1) push("R3 fires at 4096", 2, 0);
    end

    // R7: sticky
    idles(20);
    push("R7 stays low", 2, 0);
    cyc(16'hC000, 1'b1, 8'h07);
    idle();
    push("R8 C000 keeps irq", 2, 0);
    read_chk(16'hC000, "R8 C000 keeps bank");
    cyc(16'hA000, 1'b1, 8'h00);
    idle();
    push("R7 rearm keeps irq", 2, 0);

    // R2: acknowledge
    cyc(16'h8000, 1'b1, 8'h00);
    idle();
    push("R2 ack releases", 2, 1);
    idles(IRQ_CYCLES + 200);
    push("R2 stays disarmed", 2, 1);

    // R3: re-arm mid count does not restart
    cyc(16'hA000, 1'b1, 8'h00);
    idles(2000);
    cyc(16'hA000, 1'b1, 8'h00);
    for (int j = 2002; j <= IRQ_CYCLES + 1; j++) begin
      idle();
      if (j == IRQ_CYCLES)     push("R3 rearm no restart high", 2, 1);
      if (j == IRQ_CYCLES + 1) push("R3 rearm no restart low", 2, 0);
    end
    cyc(16'h9FFF, 1'b1, 8'h00);
    idle();
    push("R2 ack at 9FFF", 2, 1);

    // R9: reset mid operation
    cyc(16'hE000, 1'b1, 8'h06);
    cyc(16'hA000, 1'b1, 8'h00);
    @(negedge m2);
    rst_n = 1'b0;
    bank_m = 0;
    read_chk(16'hC000, "R9 reset clears bank");
    @(negedge m2);
    rst_n = 1'b1;
    idles(IRQ_CYCLES + 50);
    push("R9 reset disarms", 2, 1);

    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule